// File: doc/BRIEF.md
# Two-Level Tree Serializer, 8 Bits to 2 Lanes

The block turns an 8-bit word, taken once every four fast clocks, into a stream of 2-bit pairs, one pair per fast clock. The fast clock runs at half the line rate. Each pair carries one even-position bit and one odd-position bit. Together the pairs form the two interleaved lanes that a later full-rate stage merges into one line. A later output driver, outside this block, does that last merge.

The reduction is a tree of two 2:1 stages. The first stage lowers the 8-bit bus to a 4-bit bus that changes every two fast clocks. The second stage lowers that to the 2-bit output bus, which changes every fast clock. In each stage, the low half of its input goes out first. The upper half is parked in a hold register at the same moment and goes out half a stage period later. The slower clock domains are modelled as phases of a free-running counter in the fast domain, not as separate clocks.

The upstream logic watches `word_ready`. In the cycle where `word_ready` is high, it presents a word and raises `word_stb`.

Top module: `sertree_8to2`

## Requirements
- R1: While `rst` is high at a clock edge, and on the output after that edge, `pair_out` is 0 and `word_ready` is 0.
- R2: `word_ready` is high for exactly one cycle in every four. The first high cycle is the fourth cycle after `rst` is released, so cycles 3, 7, 11, … counting the first cycle after release as 0.
- R3: A word is taken only at the clock edge that ends a cycle where `word_ready` is high, and only if `word_stb` is high in that cycle.
- R4: The pair register takes bits 1 and 0 of a captured word on the second clock edge after the capture edge. Bit 0 of `pair_out` is the even lane and bit 1 is the odd lane, so `pair_out` equals word[1:0] in the third cycle after the `word_ready` cycle.
- R5: The four pairs of a word appear in consecutive cycles in the order word[1:0], word[3:2], word[5:4], word[7:6]. The line order is therefore bit 0 first through bit 7 last.
- R6: Words captured in consecutive `word_ready` cycles produce an unbroken stream. The first pair of a word directly follows the last pair of the word before it.
- R7: If `word_stb` is low in a `word_ready` cycle, the four pairs of that slot are all 0, whatever `word_in` holds.
- R8: The values of `word_in` and `word_stb` in cycles where `word_ready` is low have no effect on `pair_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| word_stb | input | 1 | Word present; sampled only in `word_ready` cycles |
| word_in | input | IN_W (8) | Parallel word, bit 0 sent first |
| word_ready | output | 1 | High in the cycle whose closing edge captures a word |
| pair_out | output | OUT_W (2) | {odd, even} interleaved pair, one per cycle |

## Verification
The hardest case to reach from the ports is the second half of a word. At that point the upper half sits in the hold registers while the input bus and the stage ahead have already moved on. A wrong hold phase only shows up when the bus carries different data at that moment. To reach it, the bench drives changing noise on `word_in` and toggles `word_stb` in every cycle where `word_ready` is low. It sends all 256 words back to back, so each hold register is always overwritten by a different value. It also places idle slots, with noise on the bus, between data words, so that zero-fill and the word boundaries are both exercised.

// File: rtl/sertree_pkg.sv
package sertree_pkg;

  // Offset of the input bus of stage k inside the packed tree bus.
  // The stage widths are iw, iw/2, iw/4 ..., so the offset is 2*iw - 2*(iw>>k).
  function automatic int bus_off(input int iw, input int k);
    return 2 * iw - 2 * (iw >> k);
  endfunction

endpackage

// File: rtl/sertree_phase.sv
module sertree_phase #(
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] ph,
  output logic          last
);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= ph_q + 1'b1;
  end

  assign ph   = ph_q;
  assign last = &ph_q;

endmodule

// File: rtl/sertree_stage.sv
module sertree_stage #(
  parameter int W   = 8,
  parameter int PL  = 2,
  parameter int OFF = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [PL-1:0]  ph,
  input  logic [W-1:0]   din,
  output logic [W/2-1:0] dout
);

  localparam int            HW    = W / 2;
  localparam int            PER   = 1 << PL;
  localparam logic [PL-1:0] LD_PH = PL'(OFF % PER);
  localparam logic [PL-1:0] HD_PH = PL'((OFF + PER / 2) % PER);

  logic [HW-1:0] hold_q;
  logic [HW-1:0] out_q;

  // Load phase: send the low half and park the upper half.
  // Half a stage period later: send the parked half.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      hold_q <= '0;
    end else if (ph == LD_PH) begin
      out_q  <= din[HW-1:0];
      hold_q <= din[W-1:HW];
    end else if (ph == HD_PH) begin
      out_q  <= hold_q;
    end
  end

  assign dout = out_q;

endmodule

// File: rtl/sertree_8to2.sv
module sertree_8to2 #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             word_stb,
  input  logic [IN_W-1:0]  word_in,
  output logic             word_ready,
  output logic [OUT_W-1:0] pair_out
);

  import sertree_pkg::*;

  localparam int NST   = $clog2(IN_W / OUT_W);
  localparam int BUS_W = 2 * IN_W - OUT_W;

  logic [NST-1:0]  ph;
  logic            cap_ph;
  logic [IN_W-1:0] cap_q;
  wire  [BUS_W-1:0] tree;

  sertree_phase #(.PW(NST)) u_phase (
    .clk  (clk),
    .rst  (rst),
    .ph   (ph),
    .last (cap_ph)
  );

  // Word capture: one slot per slow period; an empty slot sends zeros.
  always_ff @(posedge clk) begin
    if (rst)         cap_q <= '0;
    else if (cap_ph) cap_q <= word_stb ? word_in : '0;
  end

  assign tree[IN_W-1:0] = cap_q;

  for (genvar k = 0; k < NST; k++) begin : g_stage
    localparam int W_K   = IN_W >> k;
    localparam int IN_O  = bus_off(IN_W, k);
    localparam int OUT_O = bus_off(IN_W, k + 1);

    sertree_stage #(.W(W_K), .PL(NST - k), .OFF(k)) u_stg (
      .clk  (clk),
      .rst  (rst),
      .ph   (ph[NST-k-1:0]),
      .din  (tree[IN_O +: W_K]),
      .dout (tree[OUT_O +: W_K/2])
    );
  end

  assign pair_out   = tree[BUS_W-OUT_W +: OUT_W];
  assign word_ready = cap_ph;

endmodule

// File: rtl/sertree_chk.sv
module sertree_chk #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             word_stb,
  input logic [IN_W-1:0]  word_in,
  input logic             word_ready,
  input logic [OUT_W-1:0] pair_out
);

  localparam int NST = $clog2(IN_W / OUT_W);
  localparam logic [7:0] LAST = 8'((1 << NST) - 1);

  logic [7:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst || word_ready) gap_q <= '0;
    else                   gap_q <= gap_q + 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (pair_out == '0) && !word_ready);  // R1

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    word_ready |=> !word_ready);  // R2

  AST_READY_GAP: assert property (@(posedge clk) disable iff (rst)
    word_ready == (gap_q == LAST));  // R2

  if (IN_W == 8 && OUT_W == 2) begin : g_fixed
    AST_FIRST_PAIR: assert property (@(posedge clk) disable iff (rst)
      (word_ready && word_stb) |-> ##3 (pair_out == $past(word_in[1:0], 3)));  // R4

    AST_SECOND_PAIR: assert property (@(posedge clk) disable iff (rst)
      (word_ready && word_stb) |-> ##4 (pair_out == $past(word_in[3:2], 4)));  // R5

    AST_THIRD_PAIR: assert property (@(posedge clk) disable iff (rst)
      (word_ready && word_stb) |-> ##5 (pair_out == $past(word_in[5:4], 5)));  // R5

    AST_LAST_PAIR: assert property (@(posedge clk) disable iff (rst)
      (word_ready && word_stb) |-> ##6 (pair_out == $past(word_in[7:6], 6)));  // R5

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      (word_ready && !word_stb) |-> ##3 (pair_out == '0));  // R7
  end

endmodule

bind sertree_8to2 sertree_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .word_stb   (word_stb),
  .word_in    (word_in),
  .word_ready (word_ready),
  .pair_out   (pair_out)
);

// File: tb/test_sertree_8to2.sv
`timescale 1ns/1ps
module test_sertree_8to2;

  localparam int NSLOT = 288;
  localparam int NCYC  = NSLOT * 4 + 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       word_stb = 1'b0;
  logic [7:0] word_in = '0;
  wire        word_ready;
  wire  [1:0] pair_out;

  int total = 0;
  int bad   = 0;

  logic [7:0] sent [NSLOT];
  bit         idle [NSLOT];

  always #2.5 clk = ~clk;

  sertree_8to2 i_sertree_8to2 (
    .clk        (clk),
    .rst        (rst),
    .word_stb   (word_stb),
    .word_in    (word_in),
    .word_ready (word_ready),
    .pair_out   (pair_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    // Slots 0..255: every word value, back to back (R5, R6).
    // Slots 256 onward: every third slot idle with noise on the bus (R7, R8).
    for (int k = 0; k < NSLOT; k++) begin
      if (k < 256) begin
        idle[k] = 1'b0;
        sent[k] = 8'(k);
      end else begin
        idle[k] = (k % 3 == 0);
        sent[k] = idle[k] ? 8'h00 : 8'(k * 29 + 7);
      end
    end

    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int t = 0; t < NCYC; t++) begin
      // Ready pulse timing: R1 in the first cycle, R2 afterwards.
      chk((t == 0) ? "R1" : "R2", 8'(word_ready), 8'((t % 4) == 3));

      // Pair check.
      if (t < 6) begin
        chk("R1", 8'(pair_out), 8'h00);
      end else begin
        int k = (t - 6) / 4;
        int j = (t - 6) % 4;
        logic [7:0] e;
        string tag;
        e = (k < NSLOT) ? ((sent[k] >> (2 * j)) & 8'h03) : 8'h00;
        if (k >= NSLOT || idle[k])      tag = "R7";
        else if (k >= 256 && j >= 2)    tag = "R8";
        else if (j == 0 && k == 0)      tag = "R4";
        else if (j == 0)                tag = "R6";
        else if (j == 1)                tag = "R3";
        else                            tag = "R5";
        chk(tag, 8'(pair_out), e);
      end

      // Drive the inputs for this cycle.
      if (t % 4 == 3) begin
        int k = (t - 3) / 4;
        if (k < NSLOT && !idle[k]) begin
          word_in  = sent[k];
          word_stb = 1'b1;
        end else begin
          word_in  = 8'(t * 73 + 19) | 8'h01;
          word_stb = 1'b0;
        end
      end else begin
        word_in  = 8'(t * 73 + 19);
        word_stb = t[0];
      end

      @(negedge clk);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule